// File: doc/BRIEF.md
# Asynchronous Memory Cycle Controller

This block turns single requests from an internal port into complete read or write cycles on an external asynchronous memory bus, such as SRAM or NOR flash. The request address splits into two parts. Its top bits pick one of four chip selects, and the rest is the offset inside that chip select's 64 MiB window. Each chip select has its own timing. Reads and writes have separate setup, strobe and hold counts, and each chip select also has a turnaround count, a select-strobe enable, an extended-wait enable and a data-bus width (8 or 16 bits). All counts are in controller clock cycles.

A cycle runs through up to four phases. An optional turnaround comes first, then setup, then strobe, then hold. The turnaround phase is left out when the access has the same direction and the same chip select as the previous one. When select-strobe mode is on, the chip select is driven only while the strobe is active. When extended wait is on, the synchronized wait input of that chip select holds the strobe phase open. Read data is captured at the end of the strobe phase and returned with a one-cycle valid pulse.

Top module: `xmc_top`

## Requirements
- R1: After reset, req_ready is 1, every mem_cs_n bit is 1, mem_oe_n and mem_we_n are 1, and rsp_valid is 0.
- R2: The chip select index is req_addr[27:26], and the offset is req_addr[25:0]. Only mem_cs_n[index] is ever driven low, and at most one bit is low at any time.
- R3: An access has setup, strobe and hold phases of S, T and H cycles. Reads take S, T and H from the read fields of their chip select, and writes take them from the write fields. During strobe, mem_oe_n is low for a read and mem_we_n is low for a write, and the two are never low together.
- R4: A setup, strobe or hold field that is programmed to 0 gives a phase of one cycle.
- R5: req_ready drops in the cycle after a request is accepted. It returns to 1 in the cycle after the last hold cycle, so the request port stays busy for exactly turnaround + S + T + H cycles.
- R6: If the previous access went to a different chip select or ran in the other direction, a turnaround phase is placed before setup. It lasts the new chip select's 2-bit turnaround count, and no chip select is driven during it.
- R7: A read after a read, or a write after a write, to the same chip select gets no turnaround. The first access after reset also gets none.
- R8: With select-strobe on, the chip select is low only during the strobe phase. With it off, the chip select is low from the first setup cycle to the last hold cycle.
- R9: With extended wait on, a wait input that is still high after the two-flop synchronizer, once the strobe count has run out, lengthens the strobe. If the wait input is released during strobe cycle J (where J is at least T), the strobe lasts J+2 cycles. With extended wait off, the wait input has no effect.
- R10: For a read, rsp_valid is 1 for exactly one cycle, the first hold cycle. rsp_rdata then holds mem_dq_i as sampled in the last strobe cycle. On an 8-bit chip select, bits 15:8 of rsp_rdata are 0.
- R11: On an 8-bit chip select, mem_addr is the byte offset and mem_dq_o carries the low write byte, with bits 15:8 set to 0. On a 16-bit chip select, mem_addr is the offset shifted right by one and mem_dq_o is the full write word. mem_dq_oe is 1 only during write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_addr | input | 28 | Byte address: chip select in 27:26, offset below |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| cfg_rd_setup | input | 16 | Read setup count, 4 bits per chip select |
| cfg_rd_strobe | input | 24 | Read strobe count, 6 bits per chip select |
| cfg_rd_hold | input | 16 | Read hold count, 4 bits per chip select |
| cfg_wr_setup | input | 16 | Write setup count, 4 bits per chip select |
| cfg_wr_strobe | input | 24 | Write strobe count, 6 bits per chip select |
| cfg_wr_hold | input | 16 | Write hold count, 4 bits per chip select |
| cfg_turn | input | 8 | Turnaround count, 2 bits per chip select |
| cfg_sel_strobe | input | 4 | Select-strobe enable per chip select |
| cfg_ext_wait | input | 4 | Extended-wait enable per chip select |
| cfg_wide | input | 4 | 1 = 16-bit device, 0 = 8-bit device |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | 26 | External address |
| mem_dq_o | output | 16 | External write data |
| mem_dq_oe | output | 1 | External data drive enable |
| mem_dq_i | input | 16 | External read data |
| mem_wait | input | 4 | Per-chip-select wait request, active high |

## Verification
The assertions check the cycle-local rules on every cycle:
- at most one chip select is low, and the two strobes are never low together;
- a strobe never appears while the port reports ready, and any active strobe comes with a driven chip select;
- the data bus is not driven during a read strobe;
- a response valid never lasts two cycles, and ready always drops after an acceptance.

Some behaviours involve counts or history, so only the bench scenarios can show them:
- the exact phase lengths, including zero fields becoming one cycle;
- whether a turnaround appears, which depends on the previous access's chip select and direction;
- the select-strobe window;
- the J+2 strobe stretch from the synchronized wait input;
- the data path for each bus width.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
    localparam int SETUP_W  = 4;
    localparam int STROBE_W = 6;
    localparam int HOLD_W   = 4;
    localparam int TURN_W   = 2;
    localparam int CNT_W    = STROBE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    // A programmed zero still yields one cycle.
    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction
endpackage

// File: rtl/xmc_wait_sync.sv
module xmc_wait_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end
        assign sync_out[g] = stab_q;
    end
endmodule

// File: rtl/xmc_timing_sel.sv
module xmc_timing_sel
    import xmc_pkg::*;
#(
    parameter int CS_CNT = 4,
    localparam int CS_W  = $clog2(CS_CNT)
) (
    input  logic [CS_CNT*SETUP_W-1:0]  cfg_rd_setup,
    input  logic [CS_CNT*STROBE_W-1:0] cfg_rd_strobe,
    input  logic [CS_CNT*HOLD_W-1:0]   cfg_rd_hold,
    input  logic [CS_CNT*SETUP_W-1:0]  cfg_wr_setup,
    input  logic [CS_CNT*STROBE_W-1:0] cfg_wr_strobe,
    input  logic [CS_CNT*HOLD_W-1:0]   cfg_wr_hold,
    input  logic [CS_CNT*TURN_W-1:0]   cfg_turn,
    input  logic [CS_CNT-1:0]          cfg_sel_strobe,
    input  logic [CS_CNT-1:0]          cfg_ext_wait,
    input  logic [CS_CNT-1:0]          cfg_wide,
    input  logic [CS_W-1:0]            cs_idx,
    input  logic                       is_write,
    output logic [CNT_W-1:0]           setup_len,
    output logic [CNT_W-1:0]           strobe_len,
    output logic [CNT_W-1:0]           hold_len,
    output logic [TURN_W-1:0]          turn_len,
    output logic                       sel_strobe,
    output logic                       ext_wait,
    output logic                       wide
);
    logic [SETUP_W-1:0]  su;
    logic [STROBE_W-1:0] st;
    logic [HOLD_W-1:0]   ho;

    always_comb begin
        su = is_write ? cfg_wr_setup[cs_idx*SETUP_W +: SETUP_W]
                      : cfg_rd_setup[cs_idx*SETUP_W +: SETUP_W];
        st = is_write ? cfg_wr_strobe[cs_idx*STROBE_W +: STROBE_W]
                      : cfg_rd_strobe[cs_idx*STROBE_W +: STROBE_W];
        ho = is_write ? cfg_wr_hold[cs_idx*HOLD_W +: HOLD_W]
                      : cfg_rd_hold[cs_idx*HOLD_W +: HOLD_W];
        setup_len  = at_least_one(CNT_W'(su));
        strobe_len = at_least_one(CNT_W'(st));
        hold_len   = at_least_one(CNT_W'(ho));
        turn_len   = cfg_turn[cs_idx*TURN_W +: TURN_W];
        sel_strobe = cfg_sel_strobe[cs_idx];
        ext_wait   = cfg_ext_wait[cs_idx];
        wide       = cfg_wide[cs_idx];
    end
endmodule

// File: rtl/xmc_top.sv
module xmc_top
    import xmc_pkg::*;
#(
    parameter int CS_CNT = 4,
    parameter int WIN_AW = 26,
    parameter int DATA_W = 16,
    localparam int CS_W   = $clog2(CS_CNT),
    localparam int ADDR_W = WIN_AW + CS_W,
    localparam int NARROW = DATA_W / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_we,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    input  logic [CS_CNT*SETUP_W-1:0]  cfg_rd_setup,
    input  logic [CS_CNT*STROBE_W-1:0] cfg_rd_strobe,
    input  logic [CS_CNT*HOLD_W-1:0]   cfg_rd_hold,
    input  logic [CS_CNT*SETUP_W-1:0]  cfg_wr_setup,
    input  logic [CS_CNT*STROBE_W-1:0] cfg_wr_strobe,
    input  logic [CS_CNT*HOLD_W-1:0]   cfg_wr_hold,
    input  logic [CS_CNT*TURN_W-1:0]   cfg_turn,
    input  logic [CS_CNT-1:0]          cfg_sel_strobe,
    input  logic [CS_CNT-1:0]          cfg_ext_wait,
    input  logic [CS_CNT-1:0]          cfg_wide,
    output logic [CS_CNT-1:0]          mem_cs_n,
    output logic                       mem_oe_n,
    output logic                       mem_we_n,
    output logic [WIN_AW-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_dq_o,
    output logic                       mem_dq_oe,
    input  logic [DATA_W-1:0]          mem_dq_i,
    input  logic [CS_CNT-1:0]          mem_wait
);
    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [CS_W-1:0]     cs;
        logic                we;
        logic [WIN_AW-1:0]   off;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                rvld;
        logic                prev_vld;
        logic [CS_W-1:0]     prev_cs;
        logic                prev_we;
    } state_t;

    state_t q, d;

    logic [CS_W-1:0]   req_cs;
    logic [CS_W-1:0]   sel_cs;
    logic              sel_we;
    logic [CNT_W-1:0]  t_setup, t_strobe, t_hold;
    logic [TURN_W-1:0] t_turn;
    logic              t_ss, t_ew, t_wide;
    logic [CS_CNT-1:0] wait_s;
    logic              busy_cycle, cs_drive, need_turn;

    assign req_cs = req_addr[ADDR_W-1 -: CS_W];
    assign sel_cs = (q.ph == PH_IDLE) ? req_cs : q.cs;
    assign sel_we = (q.ph == PH_IDLE) ? req_we : q.we;

    xmc_timing_sel #(.CS_CNT(CS_CNT)) u_tsel (
        .cfg_rd_setup   (cfg_rd_setup),
        .cfg_rd_strobe  (cfg_rd_strobe),
        .cfg_rd_hold    (cfg_rd_hold),
        .cfg_wr_setup   (cfg_wr_setup),
        .cfg_wr_strobe  (cfg_wr_strobe),
        .cfg_wr_hold    (cfg_wr_hold),
        .cfg_turn       (cfg_turn),
        .cfg_sel_strobe (cfg_sel_strobe),
        .cfg_ext_wait   (cfg_ext_wait),
        .cfg_wide       (cfg_wide),
        .cs_idx         (sel_cs),
        .is_write       (sel_we),
        .setup_len      (t_setup),
        .strobe_len     (t_strobe),
        .hold_len       (t_hold),
        .turn_len       (t_turn),
        .sel_strobe     (t_ss),
        .ext_wait       (t_ew),
        .wide           (t_wide)
    );

    xmc_wait_sync #(.W(CS_CNT)) u_wsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mem_wait),
        .sync_out (wait_s)
    );

    assign need_turn = q.prev_vld && !(q.prev_cs == req_cs && q.prev_we == req_we)
                       && (t_turn != '0);

    always_comb begin
        d      = q;
        d.rvld = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    d.cs       = req_cs;
                    d.we       = req_we;
                    d.off      = req_addr[WIN_AW-1:0];
                    d.wdata    = req_wdata;
                    d.prev_vld = 1'b1;
                    d.prev_cs  = req_cs;
                    d.prev_we  = req_we;
                    if (need_turn) begin
                        d.ph  = PH_TURN;
                        d.cnt = CNT_W'(t_turn) - 1'b1;
                    end else begin
                        d.ph  = PH_SETUP;
                        d.cnt = t_setup - 1'b1;
                    end
                end
            end
            PH_TURN: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_SETUP;
                    d.cnt = t_setup - 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_STROBE;
                    d.cnt = t_strobe - 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (!(t_ew && wait_s[q.cs])) begin
                    d.ph  = PH_HOLD;
                    d.cnt = t_hold - 1'b1;
                    if (!q.we) begin
                        d.rvld  = 1'b1;
                        d.rdata = t_wide ? mem_dq_i
                                         : {{(DATA_W-NARROW){1'b0}}, mem_dq_i[NARROW-1:0]};
                    end
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) d.ph = PH_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_cycle = (q.ph == PH_SETUP) || (q.ph == PH_STROBE) || (q.ph == PH_HOLD);
    assign cs_drive   = t_ss ? (q.ph == PH_STROBE) : busy_cycle;

    for (genvar g = 0; g < CS_CNT; g++) begin : g_cs
        assign mem_cs_n[g] = !(cs_drive && (q.cs == CS_W'(g)));
    end

    assign mem_oe_n  = !((q.ph == PH_STROBE) && !q.we);
    assign mem_we_n  = !((q.ph == PH_STROBE) && q.we);
    assign mem_addr  = t_wide ? (q.off >> 1) : q.off;
    assign mem_dq_o  = t_wide ? q.wdata : {{(DATA_W-NARROW){1'b0}}, q.wdata[NARROW-1:0]};
    assign mem_dq_oe = busy_cycle && q.we;
    assign req_ready = (q.ph == PH_IDLE);
    assign rsp_valid = q.rvld;
    assign rsp_rdata = q.rdata;
endmodule

// File: rtl/xmc_checker.sv
module xmc_checker #(
    parameter int CS_CNT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [CS_CNT-1:0] mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n)); // R2

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R3

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R5

    AST_NO_STROBE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !req_ready); // R5

    AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1)); // R8

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R11
endmodule

bind xmc_top xmc_checker #(.CS_CNT(CS_CNT)) u_xmc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/xmc_top_bench.sv
module xmc_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [27:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] cfg_rd_setup, cfg_rd_hold, cfg_wr_setup, cfg_wr_hold;
    logic [23:0] cfg_rd_strobe, cfg_wr_strobe;
    logic [7:0]  cfg_turn;
    logic [3:0]  cfg_sel_strobe = '0, cfg_ext_wait = '0, cfg_wide = '0;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, mem_dq_oe;
    logic [25:0] mem_addr;
    logic [15:0] mem_dq_o, mem_dq_i;
    logic [3:0]  mem_wait = '0;

    logic [3:0] rs[4], rh[4], ws[4], wh[4];
    logic [5:0] rt[4], wt[4];
    logic [1:0] ta[4];

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            cfg_rd_setup[i*4 +: 4]  = rs[i];
            cfg_rd_hold[i*4 +: 4]   = rh[i];
            cfg_wr_setup[i*4 +: 4]  = ws[i];
            cfg_wr_hold[i*4 +: 4]   = wh[i];
            cfg_rd_strobe[i*6 +: 6] = rt[i];
            cfg_wr_strobe[i*6 +: 6] = wt[i];
            cfg_turn[i*2 +: 2]      = ta[i];
        end
    end

    function automatic logic [15:0] mdata(input logic [25:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] + 8'h11};
    endfunction
    assign mem_dq_i = mdata(mem_addr);

    always #(CLK_PERIOD/2) clk = ~clk;

    xmc_top u_xmc_top (.*);

    typedef struct {
        int          pre, cs_pre, strb, post, cs_post;
        logic [3:0]  cs_n;
        logic        we;
        logic [25:0] addr;
        logic [15:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;
    bit   have_prev = 0;
    int   prev_cs = 0;
    bit   prev_we = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Driver: computes the expected cycle from the requirements, queues it, issues it.
    task automatic access(input int cs, input bit we, input logic [25:0] off,
                          input logic [15:0] wd, input int wait_j);
        exp_t e;
        int turn, su, st, ho, seen;
        bit ss, wide;
        ss   = cfg_sel_strobe[cs];
        wide = cfg_wide[cs];
        turn = (have_prev && !(prev_cs == cs && prev_we == we)) ? int'(ta[cs]) : 0; // R6 R7
        su = eff(we ? int'(ws[cs]) : int'(rs[cs]));                                // R4
        st = eff(we ? int'(wt[cs]) : int'(rt[cs]));
        ho = eff(we ? int'(wh[cs]) : int'(rh[cs]));
        if (wait_j > 0) st = wait_j + 2;                                           // R9
        e.pre     = turn + su;
        e.cs_pre  = ss ? 0 : su;                                                   // R8
        e.strb    = st;
        e.post    = ho;
        e.cs_post = ss ? 0 : ho;
        e.cs_n    = ~(4'b1 << cs);                                                 // R2
        e.we      = we;
        e.addr    = wide ? (off >> 1) : off;                                       // R11
        if (we) e.data = wide ? wd : {8'h00, wd[7:0]};
        else    e.data = wide ? mdata(e.addr) : {8'h00, mdata(e.addr)[7:0]};       // R10
        exp_q.push_back(e);
        have_prev = 1; prev_cs = cs; prev_we = we;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {cs[1:0], off};
        req_we    = we;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (wait_j > 0) begin
            seen = 0;
            while (seen < wait_j) begin
                if (!mem_oe_n || !mem_we_n) seen++;
                if (seen < wait_j) @(negedge clk);
            end
            mem_wait = '0;
        end
        while (!req_ready) @(negedge clk);
    endtask

    // Monitor: measures each busy window and compares with the queued expectation.
    bit          in_acc = 0;
    int          m_pre, m_cspre, m_strb, m_post, m_cspost, m_rvpos;
    logic [3:0]  m_csn;
    logic        m_we, m_oe;
    logic [25:0] m_addr;
    logic [15:0] m_dq, m_rd;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!req_ready) begin
                if (!in_acc) begin
                    in_acc = 1; m_pre = 0; m_cspre = 0; m_strb = 0;
                    m_post = 0; m_cspost = 0; m_rvpos = 0; m_rd = '0;
                end
                if (!mem_oe_n || !mem_we_n) begin
                    if (m_strb == 0) begin
                        m_csn = mem_cs_n; m_we = !mem_we_n; m_addr = mem_addr;
                        m_dq = mem_dq_o; m_oe = mem_dq_oe;
                    end
                    m_strb++;
                end else if (m_strb == 0) begin
                    m_pre++;
                    if (mem_cs_n != 4'hF) m_cspre++;
                end else begin
                    m_post++;
                    if (mem_cs_n != 4'hF) m_cspost++;
                    if (rsp_valid) begin m_rvpos = m_post; m_rd = rsp_rdata; end
                end
            end else if (in_acc) begin
                exp_t e;
                in_acc = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected cycle", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(m_pre == e.pre, "R6", "turn+setup cycles", m_pre, e.pre);
                    chk(m_cspre == e.cs_pre, "R8", "cs low before strobe", m_cspre, e.cs_pre);
                    chk(m_strb == e.strb, "R3", "strobe cycles", m_strb, e.strb);
                    chk(m_post == e.post, "R3", "hold cycles", m_post, e.post);
                    chk(m_cspost == e.cs_post, "R8", "cs low after strobe", m_cspost, e.cs_post);
                    chk(m_csn == e.cs_n, "R2", "chip select", m_csn, e.cs_n);
                    chk(m_we == e.we, "R3", "strobe direction", m_we, e.we);
                    chk(m_addr == e.addr, "R11", "address", m_addr, e.addr);
                    if (e.we) begin
                        chk(m_dq == e.data, "R11", "write data", m_dq, e.data);
                        chk(m_oe == 1'b1, "R11", "data drive", m_oe, 1);
                        chk(m_rvpos == 0, "R10", "no rsp on write", m_rvpos, 0);
                    end else begin
                        chk(m_oe == 1'b0, "R11", "no drive on read", m_oe, 0);
                        chk(m_rvpos == 1, "R10", "rsp in first hold", m_rvpos, 1);
                        chk(m_rd == e.data, "R10", "read data", m_rd, e.data);
                    end
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            rs[i] = 4'd2; rt[i] = 6'd3; rh[i] = 4'd2;
            ws[i] = 4'd2; wt[i] = 6'd3; wh[i] = 4'd2; ta[i] = 2'd1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(mem_cs_n == 4'hF, "R1", "cs_n", mem_cs_n, 4'hF);
        chk(mem_oe_n && mem_we_n, "R1", "strobes", {mem_oe_n, mem_we_n}, 3);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);

        // R3: separate read/write fields on cs0, 8-bit; R7: first access has no turnaround
        rs[0] = 4'd3; rt[0] = 6'd4; rh[0] = 4'd2;
        ws[0] = 4'd1; wt[0] = 6'd5; wh[0] = 4'd3; ta[0] = 2'd2;
        access(0, 0, 26'h0001234, 16'h0, 0);
        access(0, 0, 26'h0003301, 16'h0, 0);      // R7 read after read
        access(0, 1, 26'h0000456, 16'hBEEF, 0);   // R6 direction change
        access(0, 1, 26'h0000457, 16'h1234, 0);   // R7 write after write
        // R4: zero fields on cs1, 16-bit; R6: chip select change
        cfg_wide[1] = 1'b1; ta[1] = 2'd3;
        ws[1] = 4'd0; wt[1] = 6'd0; wh[1] = 4'd0;
        rs[1] = 4'd0; rt[1] = 6'd0; rh[1] = 4'd0;
        access(1, 1, 26'h0002468, 16'hA55A, 0);
        access(1, 0, 26'h00013A6, 16'h0, 0);
        access(1, 0, 26'h3FFFFFE, 16'h0, 0);
        // R8: select-strobe on cs2
        cfg_sel_strobe[2] = 1'b1; ta[2] = 2'd0;
        rs[2] = 4'd4; rt[2] = 6'd2; rh[2] = 4'd3;
        access(2, 0, 26'h00000AB, 16'h0, 0);
        access(2, 1, 26'h00000CD, 16'h00F7, 0);
        // R9: extended wait on cs3, wait released in strobe cycle 8
        cfg_ext_wait[3] = 1'b1; rt[3] = 6'd3;
        mem_wait[3] = 1'b1;
        repeat (3) @(negedge clk);
        access(3, 0, 26'h0000777, 16'h0, 8);
        // R9: wait ignored when extended wait is off
        cfg_ext_wait[3] = 1'b0;
        mem_wait[3] = 1'b1;
        access(3, 0, 26'h0000778, 16'h0, 0);
        mem_wait[3] = 1'b0;
        access(0, 0, 26'h0000010, 16'h0, 0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "all cycles seen", exp_q.size(), 0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule